// File: doc/BRIEF.md
# Scalar Execute Stage

This block is the execute stage of a single-issue, 32-bit scalar control processor with a classic three-register, immediate and jump encoding. Each cycle it may accept one instruction word together with its program counter and the two source operand values already read from the register file. It computes the integer result, resolves branches and jumps, and issues data-memory and system-register accesses. Results are registered and appear one clock after the instruction is presented.

Data memory and the two system-register banks are reached through request ports that are combinational from the presented instruction. The read data returns in the same cycle and is folded into the registered writeback. System-register numbers are split between the two banks: the lower half of the numbers selects the first bank and the upper half selects the second. A break instruction sets two sticky status flags and, when enabled, pulses an interrupt request. Instructions of the vector coprocessor are not executed here. They are handed to a side port.

Arithmetic never traps. Unknown encodings raise a one-cycle illegal flag and leave every architectural output untouched. The branch-and-link-on-non-negative form always writes its return address, even when the branch is not taken.

Top module: `scx_exec_unit`

## Requirements
- R1: After reset, wb_en, br_taken, illegal, irq_req, halt, broke and vec_valid are all 0.
- R2: Major opcode bits 31:26 = 0 selects by function field bits 5:0. Functions 0x20 and 0x21 add and 0x22 and 0x23 subtract (rs minus rt). Both wrap modulo 2^32. Function 0x24/0x25/0x26/0x27 give AND/OR/XOR/NOR. The result is written to the rd field (bits 15:11) one cycle later.
- R3: A write whose destination index is 0 never asserts wb_en.
- R4: Functions 0x00/0x02/0x03 shift rt left, right logically and right arithmetically by bits 10:6. Functions 0x04/0x06/0x07 do the same by rs[4:0] only.
- R5: Function 0x2A sets 1 on signed rs<rt and 0x2B on unsigned rs<rt. Opcode 0x0B sign-extends the 16-bit immediate and then compares unsigned. Opcodes 0x0C/0x0D/0x0E zero-extend the immediate for AND/OR/XOR. Opcode 0x0F places the immediate in bits 31:16. Immediate forms write rt (bits 20:16).
- R6: Opcodes 0x04 (equal), 0x05 (not equal), 0x06 (rs<=0) and 0x07 (rs>0), and opcode 1 with rt field 0 (rs<0) or 1 (rs>=0), branch to pc+4+(sign-extended immediate shifted left by 2). br_taken is asserted with br_target one cycle later only when the condition holds.
- R7: Opcode 1 with rt field 0x11 always writes pc+8 to register 31, taken or not. Opcode 3 also writes pc+8 to register 31.
- R8: Opcodes 2 and 3 jump to {(pc+4)[31:28], bits 25:0, 2'b00}. Functions 0x08 and 0x09 jump to rs, and 0x09 writes pc+8 to rd.
- R9: Loads (opcode 0x20 byte signed, 0x24 byte unsigned, 0x21 half signed, 0x25 half unsigned, 0x23 word) read at rs+sign-extended immediate. Lanes are little-endian: the byte is selected by address bits 1:0 and the half by bit 1. Signed forms sign-extend and unsigned forms zero-extend.
- R10: Stores (0x28 byte, 0x29 half, 0x2B word) assert mem_wr with byte enables for the addressed lanes and the data replicated across lanes. They do not write back.
- R11: Opcode 0x10 with rs field 0 reads and with rs field 4 writes system register rd. rd 0..7 reaches bank A at index rd and rd 8..15 reaches bank B at index rd-8. A read writes the bank data to rt. rd of 16 or more is illegal.
- R12: Function 0x0D sets halt and broke, which stay set. irq_req pulses for one cycle only if brk_irq_en is 1.
- R13: An unknown encoding asserts illegal for exactly one cycle. It asserts no memory or system-register request and produces no writeback or branch.
- R14: Opcodes 0x12, 0x32 and 0x3A pulse vec_valid with the instruction on vec_instr one cycle later and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction |
| rs_val | input | 32 | Value of the rs source register |
| rt_val | input | 32 | Value of the rt source register |
| brk_irq_en | input | 1 | Break raises an interrupt when 1 |
| mem_rd | output | 1 | Data load request |
| mem_wr | output | 1 | Data store request |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Store byte enables |
| mem_wdata | output | 32 | Store data, lane replicated |
| mem_rdata | input | 32 | Word read at mem_addr, same cycle |
| c0a_rd | output | 1 | Bank A register read |
| c0a_wr | output | 1 | Bank A register write |
| c0b_rd | output | 1 | Bank B register read |
| c0b_wr | output | 1 | Bank B register write |
| c0_idx | output | C0_IW | Register index within the bank |
| c0_wdata | output | 32 | System register write data |
| c0a_rdata | input | 32 | Bank A read data, same cycle |
| c0b_rdata | input | 32 | Bank B read data, same cycle |
| wb_en | output | 1 | Register writeback valid |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| br_taken | output | 1 | Redirect strobe |
| br_target | output | 32 | Redirect address |
| illegal | output | 1 | Unknown instruction pulse |
| irq_req | output | 1 | Break interrupt pulse |
| halt | output | 1 | Sticky halt flag |
| broke | output | 1 | Sticky break flag |
| vec_valid | output | 1 | Vector instruction forwarded |
| vec_instr | output | 32 | Forwarded instruction word |

## Verification
Arithmetic is driven with operands at the signed boundary, for example 0x7FFFFFFF+1 and 0-1, which separates wrapping from saturating or trapping behaviour. Shifts use a negative operand with a shift-amount register whose upper bits are set, which separates arithmetic from logical shifting and shows that only five bits of the amount count. Loads read one fixed word whose bytes have mixed sign bits at several offsets, which separates the lane choice from the extension choice. Comparisons pair -1 with 1, and the unsigned immediate compare uses 0xFFFF, so signed and unsigned results disagree. Branch-and-link is run both taken and not taken, and system-register numbers are taken from both banks and beyond their range.

// File: rtl/scx_pkg.sv
package scx_pkg;

  localparam int XW = 32;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_REGIMM  = 6'h01;
  localparam logic [5:0] OP_SYSREG  = 6'h10;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } alu_op_e;

  typedef enum logic [3:0] {
    BR_NONE, BR_LTZ, BR_GEZ, BR_EQ, BR_NE, BR_LEZ, BR_GTZ, BR_ABS, BR_REG
  } br_kind_e;

  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W} mem_sz_e;

  typedef enum logic [1:0] {WB_ALU, WB_LINK, WB_LOAD, WB_SYS} wb_src_e;

  // b is the second operand; shifts act on b by sa
  function automatic logic [XW-1:0] alu_eval(alu_op_e op, logic [XW-1:0] a,
                                             logic [XW-1:0] b, logic [4:0] sa);
    case (op)
      ALU_ADD:  return a + b;
      ALU_SUB:  return a - b;
      ALU_AND:  return a & b;
      ALU_OR:   return a | b;
      ALU_XOR:  return a ^ b;
      ALU_NOR:  return ~(a | b);
      ALU_SLT:  return {{(XW-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: return {{(XW-1){1'b0}}, a < b};
      ALU_SLL:  return b << sa;
      ALU_SRL:  return b >> sa;
      ALU_SRA:  return $unsigned($signed(b) >>> sa);
      ALU_LUI:  return {b[15:0], 16'h0000};
      default:  return '0;
    endcase
  endfunction

  function automatic logic [XW-1:0] sext16(logic [15:0] v);
    return {{(XW-16){v[15]}}, v};
  endfunction

endpackage

// File: rtl/scx_alu.sv
module scx_alu
  import scx_pkg::*;
(
  input  alu_op_e        op,
  input  logic [XW-1:0]  a,
  input  logic [XW-1:0]  b,
  input  logic [4:0]     sa,
  output logic [XW-1:0]  y
);
  always_comb y = alu_eval(op, a, b, sa);
endmodule

// File: rtl/scx_branch.sv
module scx_branch
  import scx_pkg::*;
(
  input  br_kind_e       kind,
  input  logic [XW-1:0]  rs,
  input  logic [XW-1:0]  rt,
  input  logic [XW-1:0]  pc,
  input  logic [25:0]    jidx,
  output logic           taken,
  output logic [XW-1:0]  target
);
  logic [XW-1:0] pc4, rel, absj;
  logic          neg, zero;

  always_comb begin
    pc4  = pc + 32'd4;
    rel  = pc4 + {sext16(jidx[15:0]), 2'b00};
    absj = {pc4[31:28], jidx, 2'b00};
    neg  = rs[XW-1];
    zero = (rs == '0);
    target = rel;
    case (kind)
      BR_LTZ:  taken = neg;
      BR_GEZ:  taken = !neg;
      BR_EQ:   taken = (rs == rt);
      BR_NE:   taken = (rs != rt);
      BR_LEZ:  taken = neg || zero;
      BR_GTZ:  taken = !neg && !zero;
      BR_ABS:  begin taken = 1'b1; target = absj; end
      BR_REG:  begin taken = 1'b1; target = rs;   end
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/scx_lsu.sv
module scx_lsu
  import scx_pkg::*;
(
  input  mem_sz_e        sz,
  input  logic           uns,
  input  logic [XW-1:0]  base,
  input  logic [15:0]    imm,
  input  logic [XW-1:0]  st_data,
  input  logic [XW-1:0]  rdata,
  output logic [XW-1:0]  addr,
  output logic [3:0]     be,
  output logic [XW-1:0]  wdata,
  output logic [XW-1:0]  ld_val
);
  logic [XW-1:0] shifted;
  logic [15:0]   half;

  always_comb begin
    addr    = base + sext16(imm);
    shifted = rdata >> {addr[1:0], 3'b000};
    half    = addr[1] ? rdata[31:16] : rdata[15:0];
    case (sz)
      SZ_B: begin
        be     = 4'b0001 << addr[1:0];
        wdata  = {4{st_data[7:0]}};
        ld_val = {{(XW-8){shifted[7] & !uns}}, shifted[7:0]};
      end
      SZ_H: begin
        be     = addr[1] ? 4'b1100 : 4'b0011;
        wdata  = {2{st_data[15:0]}};
        ld_val = {{(XW-16){half[15] & !uns}}, half};
      end
      default: begin
        be     = 4'b1111;
        wdata  = st_data;
        ld_val = rdata;
      end
    endcase
  end
endmodule

// File: rtl/scx_exec_unit.sv
module scx_exec_unit
  import scx_pkg::*;
#(
  parameter int C0_BANK_REGS = 8,
  localparam int C0_IW = $clog2(C0_BANK_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_instr,
  input  logic [31:0]       in_pc,
  input  logic [31:0]       rs_val,
  input  logic [31:0]       rt_val,
  input  logic              brk_irq_en,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              c0a_rd,
  output logic              c0a_wr,
  output logic              c0b_rd,
  output logic              c0b_wr,
  output logic [C0_IW-1:0]  c0_idx,
  output logic [31:0]       c0_wdata,
  input  logic [31:0]       c0a_rdata,
  input  logic [31:0]       c0b_rdata,
  output logic              wb_en,
  output logic [4:0]        wb_idx,
  output logic [31:0]       wb_data,
  output logic              br_taken,
  output logic [31:0]       br_target,
  output logic              illegal,
  output logic              irq_req,
  output logic              halt,
  output logic              broke,
  output logic              vec_valid,
  output logic [31:0]       vec_instr
);

  logic [5:0]  op, fn;
  logic [4:0]  f_rs, f_rt, f_rd, f_sh;
  logic [15:0] imm;

  assign op   = in_instr[31:26];
  assign f_rs = in_instr[25:21];
  assign f_rt = in_instr[20:16];
  assign f_rd = in_instr[15:11];
  assign f_sh = in_instr[10:6];
  assign fn   = in_instr[5:0];
  assign imm  = in_instr[15:0];

  // decoded controls
  logic     legal, wb_we, is_ld, is_st, ld_uns, sys_rd, sys_wr, is_brk, is_fwd;
  logic     sa_var;
  logic [1:0] b_sel;          // 0 rt, 1 sign-ext imm, 2 zero-ext imm
  logic [4:0] wb_dst;
  alu_op_e  alu_op;
  br_kind_e br_kind;
  mem_sz_e  msz;
  wb_src_e  wb_src;
  logic     sys_ok, sys_bank_b;

  assign sys_ok     = (f_rd >> (C0_IW + 1)) == '0;
  assign sys_bank_b = f_rd[C0_IW];

  always_comb begin
    legal = 1'b1; wb_we = 1'b0; is_ld = 1'b0; is_st = 1'b0; ld_uns = 1'b0;
    sys_rd = 1'b0; sys_wr = 1'b0; is_brk = 1'b0; is_fwd = 1'b0; sa_var = 1'b0;
    b_sel = 2'd0; wb_dst = f_rd; alu_op = ALU_ADD; br_kind = BR_NONE;
    msz = SZ_W; wb_src = WB_ALU;
    case (op)
      OP_SPECIAL: begin
        wb_we = 1'b1;
        case (fn)
          6'h00: alu_op = ALU_SLL;
          6'h02: alu_op = ALU_SRL;
          6'h03: alu_op = ALU_SRA;
          6'h04: begin alu_op = ALU_SLL; sa_var = 1'b1; end
          6'h06: begin alu_op = ALU_SRL; sa_var = 1'b1; end
          6'h07: begin alu_op = ALU_SRA; sa_var = 1'b1; end
          6'h08: begin br_kind = BR_REG; wb_we = 1'b0; end
          6'h09: begin br_kind = BR_REG; wb_src = WB_LINK; end
          6'h0D: begin is_brk = 1'b1; wb_we = 1'b0; end
          6'h20, 6'h21: alu_op = ALU_ADD;
          6'h22, 6'h23: alu_op = ALU_SUB;
          6'h24: alu_op = ALU_AND;
          6'h25: alu_op = ALU_OR;
          6'h26: alu_op = ALU_XOR;
          6'h27: alu_op = ALU_NOR;
          6'h2A: alu_op = ALU_SLT;
          6'h2B: alu_op = ALU_SLTU;
          default: begin legal = 1'b0; wb_we = 1'b0; end
        endcase
      end
      OP_REGIMM: begin
        case (f_rt)
          5'h00: br_kind = BR_LTZ;
          5'h01: br_kind = BR_GEZ;
          5'h11: begin br_kind = BR_GEZ; wb_we = 1'b1; wb_src = WB_LINK; wb_dst = 5'd31; end
          default: legal = 1'b0;
        endcase
      end
      6'h02: br_kind = BR_ABS;
      6'h03: begin br_kind = BR_ABS; wb_we = 1'b1; wb_src = WB_LINK; wb_dst = 5'd31; end
      6'h04: br_kind = BR_EQ;
      6'h05: br_kind = BR_NE;
      6'h06: br_kind = BR_LEZ;
      6'h07: br_kind = BR_GTZ;
      6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F: begin
        wb_we = 1'b1; wb_dst = f_rt;
        b_sel = (op >= 6'h0C) ? 2'd2 : 2'd1;
        case (op[2:0])
          3'd2:    alu_op = ALU_SLT;
          3'd3:    alu_op = ALU_SLTU;
          3'd4:    alu_op = ALU_AND;
          3'd5:    alu_op = ALU_OR;
          3'd6:    alu_op = ALU_XOR;
          3'd7:    alu_op = ALU_LUI;
          default: alu_op = ALU_ADD;
        endcase
      end
      OP_SYSREG: begin
        if (sys_ok && f_rs == 5'd0) begin
          sys_rd = 1'b1; wb_we = 1'b1; wb_src = WB_SYS; wb_dst = f_rt;
        end else if (sys_ok && f_rs == 5'd4) begin
          sys_wr = 1'b1;
        end else begin
          legal = 1'b0;
        end
      end
      6'h12, 6'h32, 6'h3A: is_fwd = 1'b1;
      6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
        is_ld = 1'b1; wb_we = 1'b1; wb_src = WB_LOAD; wb_dst = f_rt;
        ld_uns = op[2];
        msz = (op[1:0] == 2'd0) ? SZ_B : (op[1:0] == 2'd1) ? SZ_H : SZ_W;
      end
      6'h28, 6'h29, 6'h2B: begin
        is_st = 1'b1;
        msz = (op[1:0] == 2'd0) ? SZ_B : (op[1:0] == 2'd1) ? SZ_H : SZ_W;
      end
      default: legal = 1'b0;
    endcase
  end

  // events brought out for the checker
  logic ev_fire, ev_illegal, ev_break, ev_link_always;
  assign ev_fire        = in_valid && legal;
  assign ev_illegal     = in_valid && !legal;
  assign ev_break       = ev_fire && is_brk;
  assign ev_link_always = in_valid && op == OP_REGIMM && f_rt == 5'h11;

  logic [31:0] alu_b, alu_y, tgt, ld_val, res;
  logic        taken;

  always_comb begin
    case (b_sel)
      2'd1:    alu_b = sext16(imm);
      2'd2:    alu_b = {16'h0000, imm};
      default: alu_b = rt_val;
    endcase
  end

  scx_alu u_alu (
    .op(alu_op), .a(rs_val), .b(alu_b),
    .sa(sa_var ? rs_val[4:0] : f_sh), .y(alu_y)
  );

  scx_branch u_br (
    .kind(br_kind), .rs(rs_val), .rt(rt_val), .pc(in_pc),
    .jidx(in_instr[25:0]), .taken(taken), .target(tgt)
  );

  scx_lsu u_lsu (
    .sz(msz), .uns(ld_uns), .base(rs_val), .imm(imm), .st_data(rt_val),
    .rdata(mem_rdata), .addr(mem_addr), .be(mem_be), .wdata(mem_wdata),
    .ld_val(ld_val)
  );

  assign mem_rd   = ev_fire && is_ld;
  assign mem_wr   = ev_fire && is_st;
  assign c0a_rd   = ev_fire && sys_rd && !sys_bank_b;
  assign c0b_rd   = ev_fire && sys_rd &&  sys_bank_b;
  assign c0a_wr   = ev_fire && sys_wr && !sys_bank_b;
  assign c0b_wr   = ev_fire && sys_wr &&  sys_bank_b;
  assign c0_idx   = f_rd[C0_IW-1:0];
  assign c0_wdata = rt_val;

  always_comb begin
    case (wb_src)
      WB_LINK: res = in_pc + 32'd8;
      WB_LOAD: res = ld_val;
      WB_SYS:  res = sys_bank_b ? c0b_rdata : c0a_rdata;
      default: res = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_en <= 1'b0; wb_idx <= '0; wb_data <= '0;
      br_taken <= 1'b0; br_target <= '0;
      illegal <= 1'b0; irq_req <= 1'b0; halt <= 1'b0; broke <= 1'b0;
      vec_valid <= 1'b0; vec_instr <= '0;
    end else begin
      wb_en     <= ev_fire && wb_we && (wb_dst != 5'd0);
      wb_idx    <= wb_dst;
      wb_data   <= res;
      br_taken  <= ev_fire && taken;
      br_target <= tgt;
      illegal   <= ev_illegal;
      irq_req   <= ev_break && brk_irq_en;
      halt      <= halt  || ev_break;
      broke     <= broke || ev_break;
      vec_valid <= ev_fire && is_fwd;
      vec_instr <= in_instr;
    end
  end

endmodule

// File: rtl/scx_exec_checker.sv
module scx_exec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] in_pc,
  input logic        ev_illegal,
  input logic        ev_link_always,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        c0a_rd,
  input logic        c0a_wr,
  input logic        c0b_rd,
  input logic        c0b_wr,
  input logic        wb_en,
  input logic [4:0]  wb_idx,
  input logic [31:0] wb_data,
  input logic        br_taken,
  input logic        illegal,
  input logic        irq_req,
  input logic        halt,
  input logic        broke,
  input logic        vec_valid
);

  p_zero_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_idx != 5'd0);

  p_link_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_always |=> wb_en && wb_idx == 5'd31 && wb_data == $past(in_pc) + 32'd8);

  p_one_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, c0a_rd, c0a_wr, c0b_rd, c0b_wr}));

  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt && broke);

  p_irq_after_break_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> halt && broke);

  p_illegal_no_request_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |-> !mem_rd && !mem_wr && !c0a_rd && !c0a_wr && !c0b_rd && !c0b_wr);

  p_illegal_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> illegal && !wb_en && !br_taken && !vec_valid);

  p_fwd_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !wb_en && !br_taken && !illegal);

endmodule

bind scx_exec_unit scx_exec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_pc(in_pc), .ev_illegal(ev_illegal),
  .ev_link_always(ev_link_always), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .c0a_rd(c0a_rd), .c0a_wr(c0a_wr), .c0b_rd(c0b_rd), .c0b_wr(c0b_wr),
  .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .br_taken(br_taken),
  .illegal(illegal), .irq_req(irq_req), .halt(halt), .broke(broke),
  .vec_valid(vec_valid)
);

// File: tb/tb_scx_exec_unit.sv
`timescale 1ns/1ps
module tb_scx_exec_unit;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, brk_irq_en = 1'b0;
  logic [31:0] in_instr = '0, in_pc = '0, rs_val = '0, rt_val = '0;
  logic mem_rd, mem_wr, c0a_rd, c0a_wr, c0b_rd, c0b_wr;
  logic [31:0] mem_addr, mem_wdata, c0_wdata, wb_data, br_target, vec_instr;
  logic [3:0] mem_be;
  logic [2:0] c0_idx;
  logic [4:0] wb_idx;
  logic wb_en, br_taken, illegal, irq_req, halt, broke, vec_valid;

  localparam logic [31:0] MEMWORD = 32'hF0A5_7F8C;
  wire [31:0] mem_rdata = MEMWORD;
  wire [31:0] c0a_rdata = 32'hA000_0000 | {29'd0, c0_idx};
  wire [31:0] c0b_rdata = 32'hB000_0000 | {29'd0, c0_idx};

  always #4 clk = ~clk;

  scx_exec_unit dut (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // combinational request snapshot
  logic s_rd, s_wr, s_ard, s_awr, s_brd, s_bwr;
  logic [31:0] s_addr, s_wdata, s_c0w;
  logic [3:0]  s_be;
  logic [2:0]  s_idx;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [4:0] sh, logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // present one instruction; registered results are valid on return
  task automatic issue(input logic [31:0] ins, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_instr = ins; in_pc = pc; rs_val = a; rt_val = b; in_valid = 1'b1;
    #1;
    s_rd = mem_rd; s_wr = mem_wr; s_ard = c0a_rd; s_awr = c0a_wr;
    s_brd = c0b_rd; s_bwr = c0b_wr; s_addr = mem_addr; s_wdata = mem_wdata;
    s_be = mem_be; s_idx = c0_idx; s_c0w = c0_wdata;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_wb(input string req, input logic [4:0] idx, input logic [31:0] val);
    chk(req, "wb_en", {31'd0, wb_en}, 32'd1);
    chk(req, "wb_idx", {27'd0, wb_idx}, {27'd0, idx});
    chk(req, "wb_data", wb_data, val);
  endtask

  task automatic t_reset();
    chk("R1", "wb_en", {31'd0, wb_en}, 0);
    chk("R1", "br_taken", {31'd0, br_taken}, 0);
    chk("R1", "illegal", {31'd0, illegal}, 0);
    chk("R1", "irq/halt/broke/vec", {28'd0, irq_req, halt, broke, vec_valid}, 0);
  endtask

  task automatic t_arith();
    issue(enc_r(1, 2, 3, 0, 6'h20), 0, 32'h7FFF_FFFF, 1);
    expect_wb("R2", 3, 32'h8000_0000);
    issue(enc_r(1, 2, 4, 0, 6'h21), 0, 32'hFFFF_FFFF, 2);
    expect_wb("R2", 4, 32'h0000_0001);
    issue(enc_r(1, 2, 5, 0, 6'h22), 0, 0, 1);
    expect_wb("R2", 5, 32'hFFFF_FFFF);
    issue(enc_r(1, 2, 6, 0, 6'h23), 0, 32'h8000_0000, 1);
    expect_wb("R2", 6, 32'h7FFF_FFFF);
    issue(enc_r(1, 2, 7, 0, 6'h27), 0, 32'h0F0F_0000, 32'h0000_00FF);
    expect_wb("R2", 7, 32'hF0F0_FF00);
    issue(enc_r(1, 2, 0, 0, 6'h20), 0, 5, 6);
    chk("R3", "wb_en to r0", {31'd0, wb_en}, 0);
    issue(enc_i(6'h09, 1, 0, 16'h0001), 0, 5, 0);
    chk("R3", "wb_en imm to r0", {31'd0, wb_en}, 0);
  endtask

  task automatic t_shift();
    issue(enc_r(0, 2, 8, 4, 6'h03), 0, 0, 32'h8000_0010);
    expect_wb("R4", 8, 32'hF800_0001);
    issue(enc_r(0, 2, 8, 4, 6'h02), 0, 0, 32'h8000_0010);
    expect_wb("R4", 8, 32'h0800_0001);
    issue(enc_r(1, 2, 9, 0, 6'h04), 0, 32'h0000_0024, 1);
    expect_wb("R4", 9, 32'h0000_0010);
    issue(enc_r(1, 2, 9, 0, 6'h07), 0, 32'hFFFF_FF21, 32'hFFFF_FFF8);
    expect_wb("R4", 9, 32'hFFFF_FFFC);
  endtask

  task automatic t_compare();
    issue(enc_r(1, 2, 10, 0, 6'h2A), 0, 32'hFFFF_FFFF, 1);
    expect_wb("R5", 10, 1);
    issue(enc_r(1, 2, 10, 0, 6'h2B), 0, 32'hFFFF_FFFF, 1);
    expect_wb("R5", 10, 0);
    issue(enc_i(6'h0B, 1, 11, 16'hFFFF), 0, 5, 0);
    expect_wb("R5", 11, 1);
    issue(enc_i(6'h0D, 1, 11, 16'h8000), 0, 0, 0);
    expect_wb("R5", 11, 32'h0000_8000);
    issue(enc_i(6'h0F, 1, 12, 16'h1234), 0, 32'h5555_5555, 0);
    expect_wb("R5", 12, 32'h1234_0000);
  endtask

  task automatic t_branch();
    issue(enc_i(6'h04, 1, 2, 16'hFFFF), 32'h100, 7, 7);
    chk("R6", "beq taken", {31'd0, br_taken}, 1);
    chk("R6", "beq target", br_target, 32'h100);
    issue(enc_i(6'h05, 1, 2, 16'h0004), 32'h100, 7, 7);
    chk("R6", "bne not taken", {31'd0, br_taken}, 0);
    issue(enc_i(6'h01, 1, 0, 16'h0002), 32'h100, 32'hFFFF_FFFF, 0);
    chk("R6", "bltz taken", {31'd0, br_taken}, 1);
    chk("R6", "bltz target", br_target, 32'h10C);
    issue(enc_i(6'h01, 1, 1, 16'h0002), 32'h100, 32'hFFFF_FFFF, 0);
    chk("R6", "bgez not taken", {31'd0, br_taken}, 0);
    issue(enc_i(6'h07, 1, 0, 16'h0010), 32'h100, 0, 0);
    chk("R6", "bgtz zero", {31'd0, br_taken}, 0);
  endtask

  task automatic t_link();
    issue(enc_i(6'h01, 1, 5'h11, 16'h0008), 32'h200, 32'hFFFF_FFFF, 0);
    chk("R7", "link not taken br", {31'd0, br_taken}, 0);
    expect_wb("R7", 31, 32'h208);
    issue(enc_i(6'h01, 1, 5'h11, 16'h0008), 32'h200, 0, 0);
    chk("R7", "link taken target", br_target, 32'h224);
    expect_wb("R7", 31, 32'h208);
    issue({6'h03, 26'h40}, 32'h1000_0000, 0, 0);
    expect_wb("R7", 31, 32'h1000_0008);
    chk("R8", "jal target", br_target, 32'h1000_0100);
    issue({6'h02, 26'h3FF_FFFF}, 32'h2000_0010, 0, 0);
    chk("R8", "j target", br_target, 32'h2FFF_FFFC);
    chk("R8", "j no wb", {31'd0, wb_en}, 0);
    issue(enc_r(1, 0, 5, 0, 6'h09), 32'h300, 32'h400, 0);
    chk("R8", "jalr target", br_target, 32'h400);
    expect_wb("R8", 5, 32'h308);
  endtask

  task automatic t_load();
    issue(enc_i(6'h20, 1, 13, 16'h0000), 0, 32'h1000, 0);
    chk("R9", "lb rd", {31'd0, s_rd}, 1);
    chk("R9", "lb addr", s_addr, 32'h1000);
    expect_wb("R9", 13, 32'hFFFF_FF8C);
    issue(enc_i(6'h24, 1, 13, 16'h0002), 0, 32'h1000, 0);
    expect_wb("R9", 13, 32'h0000_00A5);
    issue(enc_i(6'h20, 1, 13, 16'h0001), 0, 32'h1000, 0);
    expect_wb("R9", 13, 32'h0000_007F);
    issue(enc_i(6'h21, 1, 13, 16'h0000), 0, 32'h1000, 0);
    expect_wb("R9", 13, 32'h0000_7F8C);
    issue(enc_i(6'h21, 1, 13, 16'h0002), 0, 32'h1000, 0);
    expect_wb("R9", 13, 32'hFFFF_F0A5);
    issue(enc_i(6'h25, 1, 13, 16'h0002), 0, 32'h1000, 0);
    expect_wb("R9", 13, 32'h0000_F0A5);
    issue(enc_i(6'h23, 1, 13, 16'hFFFC), 0, 32'h1000, 0);
    chk("R9", "lw addr", s_addr, 32'h0FFC);
    expect_wb("R9", 13, MEMWORD);
  endtask

  task automatic t_store();
    issue(enc_i(6'h28, 1, 2, 16'h0003), 0, 32'h2000, 32'h1122_3344);
    chk("R10", "sb wr", {31'd0, s_wr}, 1);
    chk("R10", "sb be", {28'd0, s_be}, 32'h8);
    chk("R10", "sb data", s_wdata, 32'h4444_4444);
    chk("R10", "sb no wb", {31'd0, wb_en}, 0);
    issue(enc_i(6'h29, 1, 2, 16'h0002), 0, 32'h2000, 32'h1122_3344);
    chk("R10", "sh be", {28'd0, s_be}, 32'hC);
    chk("R10", "sh data", s_wdata, 32'h3344_3344);
    issue(enc_i(6'h2B, 1, 2, 16'h0000), 0, 32'h2000, 32'h1122_3344);
    chk("R10", "sw be", {28'd0, s_be}, 32'hF);
    chk("R10", "sw data", s_wdata, 32'h1122_3344);
  endtask

  task automatic t_sysreg();
    issue(enc_i(6'h10, 0, 4, {5'd3, 11'd0}), 0, 0, 0);
    chk("R11", "bank a rd", {30'd0, s_ard, s_brd}, 32'h2);
    chk("R11", "idx", {29'd0, s_idx}, 3);
    expect_wb("R11", 4, 32'hA000_0003);
    issue(enc_i(6'h10, 0, 4, {5'd13, 11'd0}), 0, 0, 0);
    chk("R11", "bank b rd", {30'd0, s_ard, s_brd}, 32'h1);
    chk("R11", "idx b", {29'd0, s_idx}, 5);
    expect_wb("R11", 4, 32'hB000_0005);
    issue(enc_i(6'h10, 5'd4, 2, {5'd9, 11'd0}), 0, 0, 32'h0000_DEAD);
    chk("R11", "bank b wr", {30'd0, s_awr, s_bwr}, 32'h1);
    chk("R11", "wr data", s_c0w, 32'h0000_DEAD);
    chk("R11", "mtc0 no wb", {31'd0, wb_en}, 0);
    issue(enc_i(6'h10, 0, 4, {5'd20, 11'd0}), 0, 0, 0);
    chk("R11", "rd 20 no access", {28'd0, s_ard, s_brd, s_awr, s_bwr}, 0);
    chk("R11", "rd 20 illegal", {31'd0, illegal}, 1);
  endtask

  task automatic t_break();
    brk_irq_en = 1'b0;
    issue(enc_r(0, 0, 0, 0, 6'h0D), 0, 0, 0);
    chk("R12", "halt/broke", {30'd0, halt, broke}, 32'h3);
    chk("R12", "no irq when off", {31'd0, irq_req}, 0);
    brk_irq_en = 1'b1;
    issue(enc_r(0, 0, 0, 0, 6'h0D), 0, 0, 0);
    chk("R12", "irq pulse", {31'd0, irq_req}, 1);
    @(negedge clk);
    chk("R12", "irq cleared", {31'd0, irq_req}, 0);
    chk("R12", "halt sticky", {30'd0, halt, broke}, 32'h3);
    brk_irq_en = 1'b0;
  endtask

  task automatic t_illegal();
    issue(enc_i(6'h3F, 1, 2, 16'h0000), 0, 0, 0);
    chk("R13", "illegal op", {31'd0, illegal}, 1);
    chk("R13", "no req", {26'd0, s_rd, s_wr, s_ard, s_awr, s_brd, s_bwr}, 0);
    chk("R13", "no wb/br", {30'd0, wb_en, br_taken}, 0);
    @(negedge clk);
    chk("R13", "illegal one cycle", {31'd0, illegal}, 0);
    issue(enc_r(1, 2, 3, 0, 6'h01), 0, 0, 0);
    chk("R13", "illegal fn", {31'd0, illegal}, 1);
    chk("R13", "illegal fn no wb", {31'd0, wb_en}, 0);
    issue(enc_i(6'h01, 1, 5'h02, 16'h0004), 0, 0, 0);
    chk("R13", "illegal rt kind", {31'd0, illegal}, 1);
    chk("R13", "illegal rt no br", {31'd0, br_taken}, 0);
  endtask

  task automatic t_forward();
    issue(32'h4A00_1234, 0, 0, 0);
    chk("R14", "vec_valid", {31'd0, vec_valid}, 1);
    chk("R14", "vec_instr", vec_instr, 32'h4A00_1234);
    chk("R14", "no side effect", {29'd0, wb_en, br_taken, illegal}, 0);
    issue({6'h32, 26'h0ABCDEF}, 0, 0, 0);
    chk("R14", "lwc2 fwd", {31'd0, vec_valid}, 1);
    chk("R14", "lwc2 no mem", {30'd0, s_rd, s_wr}, 0);
    @(negedge clk);
    chk("R14", "vec one cycle", {31'd0, vec_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_shift();
    t_compare();
    t_branch();
    t_link();
    t_load();
    t_store();
    t_sysreg();
    t_forward();
    t_illegal();
    t_break();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule